// File: doc/BRIEF.md
# FIFO-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on one output line. Bytes go into a 16-entry queue through a single write strobe. A frame engine takes the oldest byte, then sends a low start bit, then 7 or 8 data bits with the least significant bit first. An optional even or odd parity bit follows, and then one or two high stop bits. Between frames the line rests high. All bit timing comes from a one-cycle bit-rate enable pulse that arrives from outside, and each bit on the line lasts exactly one pulse period.

The queue is checked again as the frame ends. If a byte is waiting, its start bit follows straight after the last stop bit, with no idle time between the frames. The host watches a queue-low flag that compares the fill level with a selectable trigger level. The same flag, gated by an enable, drives an interrupt request. A transmit-end flag reports that the queue ran dry during the final stop bit. A sticky overflow flag records any write that was dropped because the queue was full. The frame format is sampled at the moment each byte is taken from the queue, so a format change made during a frame applies from the next frame.

Top module: `uart_fifo_tx`

## Requirements
- R1: After reset `txd` is 1 and `tx_end` is 1. The line stays at 1 whenever no frame is in progress, and `tx_end` is never 1 while `txd` is 0.
- R2: With `fmt_seven`=0, `fmt_par_en`=0 and `fmt_two_stop`=0, a frame is one 0 start bit, then `wr_data[0]` through `wr_data[7]` in that order, then one stop bit of 1.
- R3: With `fmt_seven`=1, only bits 0 to 6 of the byte are sent. Bit 7 has no effect on the line.
- R4: With `fmt_par_en`=1, a parity bit follows the data bits. For `fmt_par_odd`=0 the number of ones in the sent data bits plus the parity bit is even. For `fmt_par_odd`=1 that number is odd. Parity covers only the data bits that are sent.
- R5: With `fmt_two_stop`=1, two stop bits of 1 end the frame.
- R6: `txd` changes only on the clock edge that samples `bit_tick`=1. When the line is idle and a byte is queued, the start bit begins at the first such edge.
- R7: If a byte is queued when the last stop bit ends, the next start bit begins on that same tick edge, so no idle bit is sent.
- R8: The queue holds 16 bytes and sends them in write order. A write made while 16 bytes are held is dropped, and it sets `fifo_ovf`, which stays 1 until reset.
- R9: `fifo_low` is 1 exactly when the queued byte count is below the trigger level. `trig_sel` 0, 1, 2 and 3 select levels 1, 2, 4 and 8.
- R10: `irq` is 1 exactly when `fifo_low` is 1 and `irq_en` is 1.
- R11: `tx_end` becomes 1 when the last stop bit starts and the queue is empty. An accepted write clears it in the next cycle.
- R12: The format inputs are sampled when a byte is taken from the queue. A change made during a frame does not alter that frame and applies to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-rate enable; one pulse per bit |
| wr_en | input | 1 | Write strobe into the queue |
| wr_data | input | 8 | Byte to queue |
| fmt_seven | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| fmt_par_en | input | 1 | 1 = send a parity bit |
| fmt_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| fmt_two_stop | input | 1 | 1 = two stop bits |
| trig_sel | input | 2 | Trigger level select: 1, 2, 4 or 8 bytes |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial output line |
| fifo_low | output | 1 | Queue count below the trigger level |
| tx_end | output | 1 | Queue ran dry at the final stop bit |
| fifo_ovf | output | 1 | Sticky flag for a dropped write |
| irq | output | 1 | Interrupt request |

## Verification
Line bits are registered, so each new bit shows on `txd` one edge after a sampled tick. The monitor waits for a posedge with `bit_tick` high and reads the line at the following falling edge. It rebuilds each frame from queued expectations and compares the frames in order. The queue count is registered, so `fifo_low`, `irq` and `fifo_ovf` respond one edge after a write strobe. The write task returns on the falling edge after that edge, and the flag checks are made there, with ticks held off so that the count is known. `tx_end` is read at the same falling edge where the monitor logs the start of the final stop bit.

// File: rtl/uart_ftx_pkg.sv
package uart_ftx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } tx_state_e;

  typedef struct packed {
    logic seven;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_fmt_t;
endpackage

// File: rtl/uart_ftx_fifo.sv
module uart_ftx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] fill,
  output logic          accept,
  output logic          ovf
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_nxt, rptr_nxt;
  logic [CW-1:0] fill_nxt;
  logic          ovf_nxt;
  logic          take;

  always_comb begin
    accept   = push && (fill != FULL);
    take     = pop && (fill != '0);
    wptr_nxt = wptr;
    rptr_nxt = rptr;
    fill_nxt = fill;
    ovf_nxt  = ovf || (push && (fill == FULL));
    if (accept) wptr_nxt = (wptr == LAST) ? '0 : wptr + 1'b1;
    if (take)   rptr_nxt = (rptr == LAST) ? '0 : rptr + 1'b1;
    if (accept && !take)      fill_nxt = fill + 1'b1;
    else if (!accept && take) fill_nxt = fill - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
      ovf  <= 1'b0;
    end else begin
      wptr <= wptr_nxt;
      rptr <= rptr_nxt;
      fill <= fill_nxt;
      ovf  <= ovf_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= push_data;
  end

  assign pop_data = mem[rptr];
endmodule

// File: rtl/uart_ftx_serial.sv
module uart_ftx_serial
  import uart_ftx_pkg::*;
#(
  parameter int DW  = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          have_byte,
  input  logic [DW-1:0] next_byte,
  input  frame_fmt_t    fmt_in,
  output logic          pop,
  output logic          last_stop_go,
  output logic          txd
);
  localparam logic [DW-1:0] MASK_SHORT = {1'b0, {(DW-1){1'b1}}};
  localparam logic [BW-1:0] LAST_LONG  = BW'(DW - 1);
  localparam logic [BW-1:0] LAST_SHORT = BW'(DW - 2);

  tx_state_e     state, state_nxt;
  logic [DW-1:0] sh, sh_nxt;
  logic [BW-1:0] bidx, bidx_nxt;
  logic          par, par_nxt;
  logic          stop2, stop2_nxt;
  logic          txd_nxt;
  frame_fmt_t    fmt_q, fmt_nxt;
  logic [BW-1:0] last_idx;
  logic [DW-1:0] sel_mask;

  always_comb begin
    state_nxt    = state;
    sh_nxt       = sh;
    bidx_nxt     = bidx;
    par_nxt      = par;
    stop2_nxt    = stop2;
    txd_nxt      = txd;
    fmt_nxt      = fmt_q;
    pop          = 1'b0;
    last_stop_go = 1'b0;
    last_idx     = fmt_q.seven ? LAST_SHORT : LAST_LONG;
    sel_mask     = fmt_in.seven ? MASK_SHORT : '1;
    if (bit_tick) begin
      unique case (state)
        S_START: begin
          txd_nxt   = sh[0];
          sh_nxt    = sh >> 1;
          bidx_nxt  = '0;
          state_nxt = S_DATA;
        end
        S_DATA: begin
          if (bidx == last_idx) begin
            if (fmt_q.par_en) begin
              txd_nxt   = par;
              state_nxt = S_PAR;
            end else begin
              txd_nxt      = 1'b1;
              stop2_nxt    = 1'b0;
              state_nxt    = S_STOP;
              last_stop_go = !fmt_q.two_stop;
            end
          end else begin
            txd_nxt  = sh[0];
            sh_nxt   = sh >> 1;
            bidx_nxt = bidx + 1'b1;
          end
        end
        S_PAR: begin
          txd_nxt      = 1'b1;
          stop2_nxt    = 1'b0;
          state_nxt    = S_STOP;
          last_stop_go = !fmt_q.two_stop;
        end
        default: begin
          if (state == S_STOP && fmt_q.two_stop && !stop2) begin
            stop2_nxt    = 1'b1;
            txd_nxt      = 1'b1;
            last_stop_go = 1'b1;
          end else if (have_byte) begin
            pop       = 1'b1;
            sh_nxt    = next_byte;
            fmt_nxt   = fmt_in;
            par_nxt   = (^(next_byte & sel_mask)) ^ fmt_in.par_odd;
            txd_nxt   = 1'b0;
            state_nxt = S_START;
          end else begin
            txd_nxt   = 1'b1;
            state_nxt = S_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sh    <= '0;
      bidx  <= '0;
      par   <= 1'b0;
      stop2 <= 1'b0;
      txd   <= 1'b1;
      fmt_q <= '0;
    end else begin
      state <= state_nxt;
      sh    <= sh_nxt;
      bidx  <= bidx_nxt;
      par   <= par_nxt;
      stop2 <= stop2_nxt;
      txd   <= txd_nxt;
      fmt_q <= fmt_nxt;
    end
  end
endmodule

// File: rtl/uart_fifo_tx.sv
module uart_fifo_tx
  import uart_ftx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          fmt_seven,
  input  logic          fmt_par_en,
  input  logic          fmt_par_odd,
  input  logic          fmt_two_stop,
  input  logic [1:0]    trig_sel,
  input  logic          irq_en,
  output logic          txd,
  output logic          fifo_low,
  output logic          tx_end,
  output logic          fifo_ovf,
  output logic          irq
);
  logic [DW-1:0] head;
  logic [CW-1:0] fill;
  logic [CW-1:0] trig_level;
  logic          accept, pop, last_stop_go, tx_end_nxt;
  frame_fmt_t    fmt;

  assign fmt = '{seven: fmt_seven, par_en: fmt_par_en,
                 par_odd: fmt_par_odd, two_stop: fmt_two_stop};

  uart_ftx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (wr_en),
    .push_data(wr_data),
    .pop      (pop),
    .pop_data (head),
    .fill     (fill),
    .accept   (accept),
    .ovf      (fifo_ovf)
  );

  uart_ftx_serial #(.DW(DW)) u_serial (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .have_byte   (fill != '0),
    .next_byte   (head),
    .fmt_in      (fmt),
    .pop         (pop),
    .last_stop_go(last_stop_go),
    .txd         (txd)
  );

  always_comb begin
    trig_level = CW'(1) << trig_sel;
    fifo_low   = fill < trig_level;
    irq        = fifo_low && irq_en;
    tx_end_nxt = tx_end;
    if (accept)                            tx_end_nxt = 1'b0;
    else if (last_stop_go && fill == '0)   tx_end_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_end <= 1'b1;
    else        tx_end <= tx_end_nxt;
  end
endmodule

// File: rtl/uart_ftx_chk.sv
module uart_ftx_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_tick,
  input logic          wr_en,
  input logic          txd,
  input logic          tx_end,
  input logic          fifo_ovf,
  input logic          fifo_low,
  input logic [CW-1:0] fill
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  a_r1_end_is_mark: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> txd);
  a_r6_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> fifo_ovf);
  a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL);
  a_r9_low_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |-> fifo_low);
  a_r11_write_clears_end: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fill != FULL) |=> !tx_end);
endmodule

bind uart_fifo_tx uart_ftx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bit_tick(bit_tick),
  .wr_en   (wr_en),
  .txd     (txd),
  .tx_end  (tx_end),
  .fifo_ovf(fifo_ovf),
  .fifo_low(fifo_low),
  .fill    (fill)
);

// File: tb/test_uart_fifo_tx.sv
module test_uart_fifo_tx;
  localparam int TP = 6;

  typedef struct {
    logic [7:0] d;
    logic seven, pe, po, ts;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic fmt_seven = 0, fmt_par_en = 0, fmt_par_odd = 0, fmt_two_stop = 0;
  logic [1:0] trig_sel = 2'd0;
  logic irq_en = 1'b0;
  logic txd, fifo_low, tx_end, fifo_ovf, irq;

  int checks = 0, fails = 0;
  int frames_seen = 0, idle_ticks = 0;
  bit tick_on = 0, busy = 0, done = 0;
  item_t q[$];

  uart_fifo_tx i_uart_fifo_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
    .fmt_seven(fmt_seven), .fmt_par_en(fmt_par_en), .fmt_par_odd(fmt_par_odd),
    .fmt_two_stop(fmt_two_stop), .trig_sel(trig_sel), .irq_en(irq_en),
    .txd(txd), .fifo_low(fifo_low), .tx_end(tx_end), .fifo_ovf(fifo_ovf), .irq(irq));

  always #10 clk = ~clk;

  int tcnt = 0;
  always @(negedge clk) begin
    if (tick_on) begin
      bit_tick <= (tcnt == TP - 1);
      tcnt     <= (tcnt == TP - 1) ? 0 : tcnt + 1;
    end else begin
      bit_tick <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input bit expect_out);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    if (expect_out)
      q.push_back('{d: d, seven: fmt_seven, pe: fmt_par_en, po: fmt_par_odd, ts: fmt_two_stop});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Monitor: reads the line at the falling edge after each sampled tick.
  initial begin
    logic exp_bits[12];
    int len, idx;
    bit bad;
    logic [11:0] got, want;
    item_t it;
    forever begin
      @(posedge clk);
      if (bit_tick) begin
        @(negedge clk);
        if (!busy) begin
          if (txd == 1'b0) begin
            if (q.size() == 0) begin
              check(0, "R8 unexpected frame", 0, 1);
            end else begin
              it = q.pop_front();
              len = 0;
              exp_bits[len++] = 1'b0;
              for (int b = 0; b < (it.seven ? 7 : 8); b++) exp_bits[len++] = it.d[b];
              if (it.pe) exp_bits[len++] = (it.seven ? ^it.d[6:0] : ^it.d) ^ it.po;
              exp_bits[len++] = 1'b1;
              if (it.ts) exp_bits[len++] = 1'b1;
              idx = 1; bad = 0; busy = 1;
              got = '0; want = '0;
            end
          end else begin
            idle_ticks++;
          end
        end else begin
          got[idx] = txd;
          want[idx] = exp_bits[idx];
          if (txd !== exp_bits[idx]) bad = 1;
          idx++;
          if (idx == len) begin
            busy = 0;
            check(!bad, "R2 R3 R4 R5 R6 R12 frame bits", int'(got), int'(want));
            frames_seen++;
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", frames_seen, 0);
    finish_run();
  end

  task automatic wait_frames(input int n);
    wait (frames_seen >= n);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R9 R10 reset state
    check(txd == 1'b1, "R1 reset txd", txd, 1);
    check(tx_end == 1'b1, "R1 reset tx_end", tx_end, 1);
    check(fifo_low == 1'b1, "R9 reset fifo_low", fifo_low, 1);
    check(irq == 1'b0, "R10 irq masked", irq, 0);
    check(fifo_ovf == 1'b0, "R8 reset ovf", fifo_ovf, 0);

    // R2 R11 single 8N1 frame
    tick_on = 1;
    push(8'hA5, 1);
    check(tx_end == 1'b0, "R11 write clears tx_end", tx_end, 0);
    wait_frames(1);
    check(tx_end == 1'b1, "R11 tx_end at last stop", tx_end, 1);
    repeat (4 * TP) @(negedge clk);
    check(txd == 1'b1, "R1 idle mark", txd, 1);

    // R3 R4 seven bits even parity, bit 7 ignored
    fmt_seven = 1; fmt_par_en = 1; fmt_par_odd = 0;
    push(8'hD3, 1);
    push(8'h01, 1);
    wait_frames(3);
    // R4 R5 eight bits odd parity two stops
    fmt_seven = 0; fmt_par_odd = 1; fmt_two_stop = 1;
    push(8'h00, 1);
    push(8'hFF, 1);
    push(8'h3C, 1);
    wait_frames(6);
    check(tx_end == 1'b1, "R11 tx_end after burst", tx_end, 1);

    // R7 back-to-back frames: queue three with ticks held, then release
    fmt_par_en = 0; fmt_two_stop = 0;
    @(negedge clk);
    tick_on = 0;
    push(8'h11, 1); push(8'h22, 1); push(8'h33, 1);
    base = idle_ticks;
    tick_on = 1;
    wait_frames(9);
    check(idle_ticks == base, "R7 no idle bit between frames", idle_ticks - base, 0);

    // R8 R9 R10 fill with ticks held
    @(negedge clk);
    tick_on = 0;
    trig_sel = 2'd2; irq_en = 1;
    for (int i = 1; i <= 16; i++) begin
      push(8'(i * 7 + 3), 1);
      check(fifo_low == (i < 4), "R9 low vs level 4", fifo_low, int'(i < 4));
      check(irq == (i < 4), "R10 irq follows low", irq, int'(i < 4));
    end
    trig_sel = 2'd3; #1;
    check(fifo_low == 1'b0, "R9 full vs level 8", fifo_low, 0);
    check(fifo_ovf == 1'b0, "R8 no ovf at 16", fifo_ovf, 0);
    push(8'hEE, 0);
    check(fifo_ovf == 1'b1, "R8 ovf on 17th write", fifo_ovf, 1);
    tick_on = 1;
    wait_frames(25);
    repeat (4 * TP) @(negedge clk);
    check(fifo_ovf == 1'b1, "R8 ovf sticky", fifo_ovf, 1);
    check(fifo_low == 1'b1 && irq == 1'b1, "R10 irq when drained", irq, 1);
    irq_en = 0; #1;
    check(irq == 1'b0, "R10 irq disabled", irq, 0);
    trig_sel = 2'd0;

    // R12 format change during a frame
    push(8'h5A, 1);
    wait (busy == 1);
    @(negedge clk);
    fmt_seven = 1; fmt_par_en = 1; fmt_par_odd = 0; fmt_two_stop = 1;
    push(8'h81, 1);
    wait_frames(27);
    repeat (6 * TP) @(negedge clk);
    check(q.size() == 0, "R8 all queued frames sent", q.size(), 0);
    check(txd == 1'b1 && tx_end == 1'b1, "R1 final idle", txd, 1);
    finish_run();
  end
endmodule